// File: doc/BRIEF.md
# Indexed Edge Detection Bank

This block watches a wide bus of monitored signals and raises one detect bit for each signal that makes a transition of interest. Every bit position has its own detector, and each detector can be set to fire on a rising edge, a falling edge, or any change. Each detector also has a mask bit that silences it. A single-bit event flag reports whether any detector fired in the current cycle.

Configuration is indirect. Software first loads a detector index and then writes either an edge-kind code or a mask bit. That write applies to the detector the index selects. Each detector's setting can be read back as packed 32-bit words from two banks: one bank holds edge kinds and the other holds masks. The default build has 256 detectors, which gives sixteen edge-kind words and eight mask words.

Each detector compares the present value of its input with a registered copy of the value from the previous cycle. Its result is registered, so a change on the input shows up on the detect output one clock edge later and stays there for one cycle.

Top module: `edge_bank_top`

## Requirements
- R1: After reset, every edge kind reads back as rising (code 0), every mask reads back as 0, the detector index is 0 and both det_vec and det_any are 0.
- R2: A write with cfg_sel = 0 loads cfg_wdata into the detector index. A write with cfg_sel = 3 changes no stored state.
- R3: A write with cfg_sel = 1 stores the code cfg_wdata[1:0] as the edge kind of the detector at the current index. The codes are 0 for rising, 1 for falling and 2 for any change. The index itself is unchanged.
- R4: An edge-kind write with code 3 is discarded, and the detector keeps its previous kind.
- R5: A write with cfg_sel = 2 stores cfg_wdata[0] as the mask bit of the detector at the current index.
- R6: With rd_bank = 0, rd_data is word rd_word of the edge-kind bank. Bits [2j+1:2j] of word w hold the kind of detector 16w+j.
- R7: With rd_bank = 1, rd_data is word rd_word of the mask bank, and bit j of word w holds the mask of detector 32w+j. A word number past the last mask word reads 0. Readback is combinational.
- R8: A rising-kind detector sets its det_vec bit in the cycle after the clock edge at which its input is first sampled high following a low sample.
- R9: A falling-kind detector sets its det_vec bit in the cycle after the clock edge at which its input is first sampled low following a high sample.
- R10: An any-change detector sets its det_vec bit in the cycle after any edge at which its sampled input differs from the previous sample. With no change, the bit is 0.
- R11: A detector whose mask bit was 1 at the sampling edge never asserts its det_vec bit.
- R12: det_any is 1 exactly when at least one det_vec bit is 1.
- R13: The first clock edge after reset only captures the input, so no detector fires there, whatever the input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 index, 1 edge kind, 2 mask, 3 none |
| cfg_wdata | input | IDX_W | Write data (index, or code in [1:0], or mask in [0]) |
| rd_bank | input | 1 | Readback bank: 0 edge kinds, 1 masks |
| rd_word | input | RDW_W | Readback word number |
| rd_data | output | 32 | Packed readback word |
| mon_in | input | NUM_DET | Monitored input bus |
| det_vec | output | NUM_DET | Registered per-detector hit vector |
| det_any | output | 1 | OR of all hits, registered with det_vec |

## Verification
The bound checker checks on every cycle that masked detectors stay quiet, that det_any tracks the OR of det_vec, and that no stored kind ever holds the reserved code. It also checks that index, kind and mask writes land where the write strobe and the current index say they should, and that nothing fires at the first edge after reset. Whether each kind reacts to the right transition, and whether the packed readback words put every field in the right bit position, can only be shown by the bench. The bench sweeps pseudo-random input sequences over three rotations of the kind assignment and compares the results with an arithmetic model.

// File: rtl/edge_bank_pkg.sv
package edge_bank_pkg;

    localparam int WORD_W        = 32;
    localparam int KIND_W        = 2;
    localparam int KINDS_PER_WORD = WORD_W / KIND_W;
    localparam int MASKS_PER_WORD = WORD_W;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_ANY  = 2'd2,
        EDGE_RSVD = 2'd3
    } edge_kind_e;

    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_KIND  = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        edge_kind_e kind;
        logic       masked;
    } det_cfg_t;

    function automatic logic kind_legal(input logic [1:0] code);
        return code != EDGE_RSVD;
    endfunction

    function automatic logic edge_hit(input edge_kind_e kind,
                                      input logic cur,
                                      input logic prv);
        logic h;
        unique case (kind)
            EDGE_RISE: h = cur & ~prv;
            EDGE_FALL: h = ~cur & prv;
            EDGE_ANY:  h = cur ^ prv;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs
    import edge_bank_pkg::*;
#(
    parameter int NUM_DET = 256,
    parameter int IDX_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [IDX_W-1:0]        cfg_wdata,
    output logic [IDX_W-1:0]        cur_idx,
    output logic [KIND_W*NUM_DET-1:0] kind_flat,
    output logic [NUM_DET-1:0]      mask_vec
);

    cfg_sel_e sel;
    logic     wr_index;
    logic     wr_kind;
    logic     wr_mask;

    assign sel      = cfg_sel_e'(cfg_sel);
    assign wr_index = cfg_we && (sel == SEL_INDEX);
    assign wr_kind  = cfg_we && (sel == SEL_KIND) && kind_legal(cfg_wdata[1:0]);
    assign wr_mask  = cfg_we && (sel == SEL_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= '0;
        end else if (wr_index) begin
            cur_idx <= cfg_wdata;
        end
    end

    for (genvar g = 0; g < NUM_DET; g++) begin : g_ent
        det_cfg_t ent_q;
        logic     hit_idx;

        assign hit_idx = (cur_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q.kind   <= EDGE_RISE;
                ent_q.masked <= 1'b0;
            end else begin
                if (wr_kind && hit_idx) begin
                    ent_q.kind <= edge_kind_e'(cfg_wdata[1:0]);
                end
                if (wr_mask && hit_idx) begin
                    ent_q.masked <= cfg_wdata[0];
                end
            end
        end

        assign kind_flat[KIND_W*g +: KIND_W] = ent_q.kind;
        assign mask_vec[g]                   = ent_q.masked;
    end

endmodule

// File: rtl/edge_readback.sv
module edge_readback
    import edge_bank_pkg::*;
#(
    parameter int NUM_DET = 256,
    parameter int RDW_W   = 4
) (
    input  logic [KIND_W*NUM_DET-1:0] kind_flat,
    input  logic [NUM_DET-1:0]        mask_vec,
    input  logic                      rd_bank,
    input  logic [RDW_W-1:0]          rd_word,
    output logic [WORD_W-1:0]         rd_data
);

    localparam int KWORDS = NUM_DET / KINDS_PER_WORD;
    localparam int MWORDS = NUM_DET / MASKS_PER_WORD;

    logic [WORD_W-1:0] kword [KWORDS];
    logic [WORD_W-1:0] mword [MWORDS];

    for (genvar w = 0; w < KWORDS; w++) begin : g_kw
        assign kword[w] = kind_flat[WORD_W*w +: WORD_W];
    end

    for (genvar w = 0; w < MWORDS; w++) begin : g_mw
        assign mword[w] = mask_vec[WORD_W*w +: WORD_W];
    end

    always_comb begin
        rd_data = '0;
        if (!rd_bank) begin
            for (int w = 0; w < KWORDS; w++) begin
                if (int'(rd_word) == w) rd_data = kword[w];
            end
        end else begin
            for (int w = 0; w < MWORDS; w++) begin
                if (int'(rd_word) == w) rd_data = mword[w];
            end
        end
    end

endmodule

// File: rtl/edge_cell.sv
module edge_cell
    import edge_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       primed,
    input  logic       mon,
    input  logic [1:0] kind,
    input  logic       masked,
    output logic       hit_d,
    output logic       hit_q
);

    logic prev_q;

    assign hit_d = primed && !masked && edge_hit(edge_kind_e'(kind), mon, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            prev_q <= mon;
            hit_q  <= hit_d;
        end
    end

endmodule

// File: rtl/edge_bank_top.sv
module edge_bank_top
    import edge_bank_pkg::*;
#(
    parameter  int NUM_DET = 256,
    localparam int IDX_W   = $clog2(NUM_DET),
    localparam int RDW_W   = $clog2(NUM_DET / KINDS_PER_WORD)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [IDX_W-1:0]   cfg_wdata,
    input  logic               rd_bank,
    input  logic [RDW_W-1:0]   rd_word,
    output logic [WORD_W-1:0]  rd_data,
    input  logic [NUM_DET-1:0] mon_in,
    output logic [NUM_DET-1:0] det_vec,
    output logic               det_any
);

    logic [IDX_W-1:0]          cur_idx;
    logic [KIND_W*NUM_DET-1:0] kind_flat;
    logic [NUM_DET-1:0]        mask_vec;
    logic [NUM_DET-1:0]        hit_d;
    logic                      primed;

    edge_cfg_regs #(
        .NUM_DET (NUM_DET),
        .IDX_W   (IDX_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cur_idx   (cur_idx),
        .kind_flat (kind_flat),
        .mask_vec  (mask_vec)
    );

    edge_readback #(
        .NUM_DET (NUM_DET),
        .RDW_W   (RDW_W)
    ) u_rd (
        .kind_flat (kind_flat),
        .mask_vec  (mask_vec),
        .rd_bank   (rd_bank),
        .rd_word   (rd_word),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    for (genvar g = 0; g < NUM_DET; g++) begin : g_det
        edge_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .primed (primed),
            .mon    (mon_in[g]),
            .kind   (kind_flat[KIND_W*g +: KIND_W]),
            .masked (mask_vec[g]),
            .hit_d  (hit_d[g]),
            .hit_q  (det_vec[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) det_any <= 1'b0;
        else     det_any <= |hit_d;
    end

endmodule

// File: rtl/edge_bank_chk.sv
module edge_bank_chk
    import edge_bank_pkg::*;
#(
    parameter int NUM_DET = 256,
    parameter int IDX_W   = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      cfg_we,
    input logic [1:0]                cfg_sel,
    input logic [IDX_W-1:0]          cfg_wdata,
    input logic [IDX_W-1:0]          cur_idx,
    input logic [KIND_W*NUM_DET-1:0] kind_flat,
    input logic [NUM_DET-1:0]        mask_vec,
    input logic [NUM_DET-1:0]        det_vec,
    input logic                      det_any
);

    logic       rsv_seen;
    logic [1:0] kind_here;
    logic       mask_here;

    always_comb begin
        rsv_seen = 1'b0;
        for (int i = 0; i < NUM_DET; i++) begin
            if (kind_flat[KIND_W*i +: KIND_W] == EDGE_RSVD) rsv_seen = 1'b1;
        end
    end

    assign kind_here = kind_flat[KIND_W*int'(cur_idx) +: KIND_W];
    assign mask_here = mask_vec[cur_idx];

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_INDEX) |=> (cur_idx == $past(cfg_wdata))); // R2

    AST_KIND_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_KIND && cfg_wdata[1:0] != 2'd3)
        |=> (kind_here == $past(cfg_wdata[1:0]))); // R3

    AST_RSVD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_KIND && cfg_wdata[1:0] == 2'd3)
        |=> $stable(kind_flat)); // R4

    AST_NO_RSVD: assert property (@(posedge clk) disable iff (rst)
        !rsv_seen); // R4

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_MASK) |=> (mask_here == $past(cfg_wdata[0]))); // R5

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((det_vec & $past(mask_vec)) == '0)); // R11

    AST_ANY_OR: assert property (@(posedge clk) disable iff (rst)
        det_any == (|det_vec)); // R12

    AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (det_vec == '0 && !det_any)); // R13

endmodule

bind edge_bank_top edge_bank_chk #(
    .NUM_DET (NUM_DET),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cur_idx   (cur_idx),
    .kind_flat (kind_flat),
    .mask_vec  (mask_vec),
    .det_vec   (det_vec),
    .det_any   (det_any)
);

// File: tb/sim_edge_bank_top.sv
module sim_edge_bank_top;

    localparam int N     = 32;
    localparam int IDX_W = 5;
    localparam int RDW_W = 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = 2'd0;
    logic [IDX_W-1:0] cfg_wdata = '0;
    logic             rd_bank = 1'b0;
    logic [RDW_W-1:0] rd_word = '0;
    logic [31:0]      rd_data;
    logic [N-1:0]     mon_in = '1;
    logic [N-1:0]     det_vec;
    logic             det_any;

    int checks = 0;
    int errors = 0;

    logic [1:0]   m_kind [N];
    logic [N-1:0] m_mask;
    logic [N-1:0] m_prev;
    logic [31:0]  rng = 32'h1234_5678;

    always #5 clk = ~clk;

    edge_bank_top #(.NUM_DET(N)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rd_bank   (rd_bank),
        .rd_word   (rd_word),
        .rd_data   (rd_data),
        .mon_in    (mon_in),
        .det_vec   (det_vec),
        .det_any   (det_any)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [IDX_W-1:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic logic [31:0] exp_kword(input int w);
        logic [31:0] v = '0;
        for (int j = 0; j < 16; j++) v[2*j +: 2] = m_kind[16*w + j];
        return v;
    endfunction

    task automatic check_readback(input string req);
        for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            rd_bank = 1'b0;
            rd_word = RDW_W'(w);
            #1 chk({req, " R6 kind word"}, rd_data, exp_kword(w));
        end
        rd_bank = 1'b1;
        rd_word = 1'b0;
        #1 chk({req, " R7 mask word0"}, rd_data, m_mask);
        rd_word = 1'b1;
        #1 chk("R7 mask word past end", rd_data, 32'h0);
    endtask

    task automatic program_all(input int phase);
        for (int i = 0; i < N; i++) begin
            m_kind[i] = 2'((i + phase) % 3);
            m_mask[i] = (((i * 5 + phase) % 7) == 0);
            wr(2'd0, IDX_W'(i));
            wr(2'd1, {3'b000, m_kind[i]});
            wr(2'd2, {4'b0000, m_mask[i]});
        end
    endtask

    function automatic logic [N-1:0] model_hits(input logic [N-1:0] cur);
        logic [N-1:0] h = '0;
        for (int i = 0; i < N; i++) begin
            case (m_kind[i])
                2'd0: h[i] = cur[i] & ~m_prev[i];
                2'd1: h[i] = ~cur[i] & m_prev[i];
                2'd2: h[i] = cur[i] ^ m_prev[i];
                default: h[i] = 1'b0;
            endcase
        end
        return h & ~m_mask;
    endfunction

    task automatic step(input logic [N-1:0] v);
        logic [N-1:0] e;
        @(negedge clk);
        mon_in = v;
        e      = model_hits(v);
        m_prev = v;
        @(negedge clk);
        chk("R8/R9/R10 det_vec", det_vec, e);
        chk("R11 masked bits quiet", det_vec & m_mask, 32'h0);
        chk("R12 det_any", {31'b0, det_any}, {31'b0, |e});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog got running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_kind[i] = 2'd0;
        m_mask = '0;
        m_prev = '1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 first edge quiet det_vec", det_vec, 32'h0);
        chk("R13 first edge quiet det_any", {31'b0, det_any}, 32'h0);
        chk("R1 det_vec after reset", det_vec, 32'h0);
        check_readback("R1 reset");

        wr(2'd1, 5'd2);
        m_kind[0] = 2'd2;
        check_readback("R1 index zero after reset");

        for (int phase = 0; phase < 3; phase++) begin
            program_all(phase);
            check_readback("R3 R5 programmed");

            wr(2'd0, 5'd3);
            wr(2'd1, 5'd3);
            wr(2'd0, 5'd17);
            wr(2'd1, 5'd7);
            check_readback("R4 code 3 ignored");

            wr(2'd3, 5'd1);
            wr(2'd2, 5'd0);
            m_mask[17] = 1'b0;
            wr(2'd3, 5'd9);
            wr(2'd1, 5'd1);
            m_kind[17] = 2'd1;
            check_readback("R2 select 3 no effect");

            step('0);
            step('1);
            step('1);
            step('0);
            for (int s = 0; s < 60; s++) begin
                rng = rng ^ (rng << 13);
                rng = rng ^ (rng >> 17);
                rng = rng ^ (rng << 5);
                step(rng);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule